// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block is the control sequencer for the instruction-fetch phase of a small processor. It works with memory that holds one byte per 16-bit address. It gathers an instruction of one to four bytes into a 32-bit instruction register. The sequencer emits no data itself. For each byte it raises three kinds of strobe in turn:

- a strobe that copies the program counter into the memory address register and increments the counter;
- a read request, which stays up until memory reports completion;
- a load strobe for the instruction-register byte lane that comes next.

After each byte lands, the sequencer looks at opcode-group flags. Decode logic outside the block derives these flags from the bytes already held. The flags decide whether the instruction is complete. Some instructions need no address calculation: a one-byte instruction with no operands, a two-byte branch, or a three-byte jump. For these, the phase ends by handing control straight to execute. Other instructions carry an address field. This field is complete after two bytes for some instructions and after four bytes for the rest. For these, the phase ends by handing control to address calculation. In either case the sequencer clears the fetch-phase flag at the same time.

The surrounding control unit starts the sequencer by holding the run flag and the fetch-phase flag high. Bytes are stored most significant first: the first byte fills bits 31..24 and the fourth fills bits 7..0.

Top module: `ifetch_seq`

## Requirements
- R1: While idle, the sequencer starts a fetch only when run_i and fetch_i are both high in the same cycle. Otherwise every output stays low.
- R2: Each byte access follows a fixed pattern. It begins with one cycle in which mar_ld_o and pc_inc_o are both high. Next comes a read phase with mem_rd_o high. In the cycle after the read phase, exactly one bit of ir_ld_o is high. With zero wait states, an N-byte fetch spans 4*N cycles from the first mar_ld_o cycle to the fetch_clr_o cycle.
- R3: mem_rd_o stays high, one cycle at a time, until a cycle in which mem_done_i is high. It drops in the following cycle. Each added wait cycle lengthens the fetch by one cycle per byte.
- R4: The ir_ld_o strobes fire in a fixed order:
  - ir_ld_o[3] (bits 31..24) for the first byte;
  - ir_ld_o[2] for the second;
  - ir_ld_o[1] for the third;
  - ir_ld_o[0] (bits 7..0) for the fourth.

  At most one bit is ever high.
- R5: The flags are sampled in the cycle after a byte's load strobe. If noop_grp_i is high after the first byte, fetch ends with exec_set_o.
- R6: After the second byte, branch2_i ends fetch with exec_set_o. This holds even when addr2_i is also high.
- R7: After the second byte, if branch2_i is low and addr2_i is high, fetch ends with addr_set_o.
- R8: After the third byte, jump3_i ends fetch with exec_set_o.
- R9: An instruction not ended earlier is fetched in full, four bytes, and ends with addr_set_o. Each flag is honoured only at its own byte position.
- R10: The end of fetch is a single cycle in which fetch_clr_o is high together with exactly one of addr_set_o and exec_set_o. That cycle directly follows the flag-sampling cycle.
- R11: A synchronous reset (rst high at a clock edge) returns the sequencer to idle with every output low, even in the middle of a read.
- R12: While run_i is low the sequencer issues no address, read or load strobe, even with fetch_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Processor running flag |
| fetch_i | input | 1 | Fetch-phase flag |
| mem_done_i | input | 1 | Memory read complete |
| noop_grp_i | input | 1 | First byte is a no-operand opcode |
| branch2_i | input | 1 | Instruction is a two-byte branch |
| addr2_i | input | 1 | Address field complete after two bytes |
| jump3_i | input | 1 | Instruction is a three-byte jump |
| mar_ld_o | output | 1 | Load address register from program counter |
| pc_inc_o | output | 1 | Increment program counter |
| mem_rd_o | output | 1 | Memory read request |
| ir_ld_o | output | NBYTES | Instruction register byte-lane load strobes, bit 3 = bits 31..24 |
| fetch_clr_o | output | 1 | Clear fetch-phase flag |
| addr_set_o | output | 1 | Set address-phase flag |
| exec_set_o | output | 1 | Set execute-phase flag |

## Verification
The bench drives opcodes whose group flags rise early, such as a jump opcode that is already flagged after its first byte or an address-complete opcode flagged from its first byte. A design that samples a flag at the wrong byte position would end fetch too early, with a short instruction register and the wrong exit. One opcode raises both the branch and the address-complete flags. A design with the priority reversed would exit to address calculation instead of execute. Varied wait-state counts and a reset in the middle of a read expose the remaining faults:
- a read that drops early;
- an off-by-one in the per-byte cycle count;
- a swapped byte lane;
- a sequencer that keeps strobing after reset or while the processor is halted.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_READ  = 3'd2,
    ST_LOAD  = 3'd3,
    ST_CHECK = 3'd4,
    ST_END   = 3'd5
  } ifs_step_e;

  typedef struct packed {
    logic done;
    logic to_exec;
  } ifs_exit_t;

  // Decide whether fetch stops after the byte just loaded, and where it goes.
  function automatic ifs_exit_t pick_exit(
    input logic at_first,
    input logic at_second,
    input logic at_third,
    input logic at_last,
    input logic noop_grp,
    input logic branch2,
    input logic addr2,
    input logic jump3
  );
    ifs_exit_t r;
    r = '0;
    if (at_first && noop_grp) begin
      r.done = 1'b1; r.to_exec = 1'b1;
    end else if (at_second && branch2) begin
      r.done = 1'b1; r.to_exec = 1'b1;
    end else if (at_second && addr2) begin
      r.done = 1'b1; r.to_exec = 1'b0;
    end else if (at_third && jump3) begin
      r.done = 1'b1; r.to_exec = 1'b1;
    end else if (at_last) begin
      r.done = 1'b1; r.to_exec = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/ifs_exit_decide.sv
module ifs_exit_decide
  import ifs_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic [IDX_W-1:0] byte_idx,
  input  logic             noop_grp,
  input  logic             branch2,
  input  logic             addr2,
  input  logic             jump3,
  output ifs_exit_t        verdict
);

  logic at_first, at_second, at_third, at_last;

  assign at_first  = (byte_idx == IDX_W'(0));
  assign at_second = (byte_idx == IDX_W'(1));
  assign at_third  = (byte_idx == IDX_W'(2));
  assign at_last   = (byte_idx == IDX_W'(NBYTES - 1));

  assign verdict = pick_exit(at_first, at_second, at_third, at_last,
                             noop_grp, branch2, addr2, jump3);

endmodule

// File: rtl/ifs_strobe_dec.sv
module ifs_strobe_dec #(
  parameter int NBYTES = 4,
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              en,
  input  logic [IDX_W-1:0]  byte_idx,
  output logic [NBYTES-1:0] strobe
);

  // Byte g of the instruction lands in the lane counted from the top.
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign strobe[NBYTES-1-g] = en && (byte_idx == IDX_W'(g));
  end

endmodule

// File: rtl/ifs_step_ctrl.sv
module ifs_step_ctrl
  import ifs_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_ok,
  input  logic             read_fin,
  input  ifs_exit_t        verdict,
  output ifs_step_e        step,
  output logic [IDX_W-1:0] byte_idx,
  output logic             to_exec
);

  ifs_step_e step_nx;

  always_comb begin
    step_nx = step;
    unique case (step)
      ST_IDLE:  if (start_ok) step_nx = ST_ADDR;
      ST_ADDR:  step_nx = ST_READ;
      ST_READ:  if (read_fin) step_nx = ST_LOAD;
      ST_LOAD:  step_nx = ST_CHECK;
      ST_CHECK: step_nx = verdict.done ? ST_END : ST_ADDR;
      ST_END:   step_nx = ST_IDLE;
      default:  step_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= ST_IDLE;
      byte_idx <= '0;
      to_exec  <= 1'b0;
    end else begin
      step <= step_nx;
      if (step == ST_IDLE) begin
        byte_idx <= '0;
      end else if (step == ST_CHECK) begin
        if (verdict.done) to_exec <= verdict.to_exec;
        else              byte_idx <= byte_idx + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
  import ifs_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              fetch_i,
  input  logic              mem_done_i,
  input  logic              noop_grp_i,
  input  logic              branch2_i,
  input  logic              addr2_i,
  input  logic              jump3_i,
  output logic              mar_ld_o,
  output logic              pc_inc_o,
  output logic              mem_rd_o,
  output logic [NBYTES-1:0] ir_ld_o,
  output logic              fetch_clr_o,
  output logic              addr_set_o,
  output logic              exec_set_o
);

  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  ifs_step_e        step;
  logic [IDX_W-1:0] byte_idx;
  logic             to_exec;
  ifs_exit_t        verdict;

  // Named internal events, visible to the bound checker.
  logic in_idle, start_ok, read_fin, byte_load, exit_now;

  assign in_idle   = (step == ST_IDLE);
  assign start_ok  = run_i && fetch_i;
  assign read_fin  = (step == ST_READ) && mem_done_i;
  assign byte_load = (step == ST_LOAD);
  assign exit_now  = (step == ST_END);

  ifs_step_ctrl #(.NBYTES(NBYTES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_ok (start_ok),
    .read_fin (read_fin),
    .verdict  (verdict),
    .step     (step),
    .byte_idx (byte_idx),
    .to_exec  (to_exec)
  );

  ifs_exit_decide #(.NBYTES(NBYTES)) u_decide (
    .byte_idx (byte_idx),
    .noop_grp (noop_grp_i),
    .branch2  (branch2_i),
    .addr2    (addr2_i),
    .jump3    (jump3_i),
    .verdict  (verdict)
  );

  ifs_strobe_dec #(.NBYTES(NBYTES)) u_strobe (
    .en       (byte_load),
    .byte_idx (byte_idx),
    .strobe   (ir_ld_o)
  );

  assign mar_ld_o    = (step == ST_ADDR);
  assign pc_inc_o    = (step == ST_ADDR);
  assign mem_rd_o    = (step == ST_READ);
  assign fetch_clr_o = exit_now;
  assign exec_set_o  = exit_now && to_exec;
  assign addr_set_o  = exit_now && !to_exec;

endmodule

// File: rtl/ifs_checker.sv
module ifs_checker #(
  parameter int NBYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              run_i,
  input logic              fetch_i,
  input logic              mem_done_i,
  input logic              in_idle,
  input logic              mar_ld_o,
  input logic              mem_rd_o,
  input logic [NBYTES-1:0] ir_ld_o,
  input logic              fetch_clr_o,
  input logic              addr_set_o,
  input logic              exec_set_o
);

  AST_IDLE_GATED: assert property (@(posedge clk) disable iff (rst)
    (in_idle && !(run_i && fetch_i)) |=> !mar_ld_o); // R1

  AST_ADDR_THEN_READ: assert property (@(posedge clk) disable iff (rst)
    mar_ld_o |=> mem_rd_o); // R2

  AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o && mem_done_i) |=> ($countones(ir_ld_o) == 1)); // R2

  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o && !mem_done_i) |=> mem_rd_o); // R3

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ir_ld_o)); // R4

  AST_EXIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(addr_set_o && exec_set_o)); // R10

  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (addr_set_o || exec_set_o) |-> fetch_clr_o); // R10

  AST_EXIT_AFTER_CHECK: assert property (@(posedge clk) disable iff (rst)
    fetch_clr_o |-> ($past(ir_ld_o) == '0 && !$past(mem_rd_o))); // R10

  AST_HALT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (in_idle && !run_i) |=> (!mar_ld_o && !mem_rd_o)); // R12

endmodule

bind ifetch_seq ifs_checker #(.NBYTES(NBYTES)) u_ifs_checker (
  .clk         (clk),
  .rst         (rst),
  .run_i       (run_i),
  .fetch_i     (fetch_i),
  .mem_done_i  (mem_done_i),
  .in_idle     (in_idle),
  .mar_ld_o    (mar_ld_o),
  .mem_rd_o    (mem_rd_o),
  .ir_ld_o     (ir_ld_o),
  .fetch_clr_o (fetch_clr_o),
  .addr_set_o  (addr_set_o),
  .exec_set_o  (exec_set_o)
);

// File: tb/ifetch_seq_bench.sv
module ifetch_seq_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, run_i = 1'b0, fetch_req = 1'b0, mem_done_i = 1'b0;
  logic noop_f, br2_f, adr2_f, jmp3_f;
  logic mar_ld_o, pc_inc_o, mem_rd_o, fetch_clr_o, addr_set_o, exec_set_o;
  logic [3:0] ir_ld_o;

  ifetch_seq u_ifetch_seq (
    .clk(clk), .rst(rst), .run_i(run_i), .fetch_i(fetch_req),
    .mem_done_i(mem_done_i), .noop_grp_i(noop_f), .branch2_i(br2_f),
    .addr2_i(adr2_f), .jump3_i(jmp3_f), .mar_ld_o(mar_ld_o),
    .pc_inc_o(pc_inc_o), .mem_rd_o(mem_rd_o), .ir_ld_o(ir_ld_o),
    .fetch_clr_o(fetch_clr_o), .addr_set_o(addr_set_o), .exec_set_o(exec_set_o)
  );

  // ---------------- environment model (only writer of its state) -------------
  logic [7:0]  mem [256];
  logic [15:0] pc = 16'h0040, mar = '0;
  logic [31:0] ir = '0, last_ir = '0;
  logic [7:0]  rdata = '0;
  int cyc = 0, mar_cnt = 0, rd_cnt = 0, end_cnt = 0, strobe_err = 0;
  int nbytes = 0, last_n = 0, start_cyc = 0, last_len = 0, rd_wait = 0;
  int wait_n = 0;
  bit in_fetch = 0, last_exec = 0, last_addr = 0;

  // Opcode groups seen by the external decoder (bench encoding).
  assign noop_f = (ir[31:30] == 2'b11);
  assign br2_f  = (ir[31:29] == 3'b100);
  assign jmp3_f = (ir[31:29] == 3'b101);
  assign adr2_f = (ir[31:28] == 4'b0100) || (ir[31:24] == 8'h8F);

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      ir = '0; nbytes = 0; in_fetch = 0; rd_wait = 0; mem_done_i = 1'b0;
    end else begin
      if (mar_ld_o) begin
        if (!in_fetch) begin start_cyc = cyc; in_fetch = 1; end
        mar_cnt++;
        mar = pc;
      end
      if (pc_inc_o) pc = pc + 16'd1;
      if (mem_rd_o) begin
        rd_cnt++;
        if (rd_wait >= wait_n) begin mem_done_i = 1'b1; rdata = mem[mar[7:0]]; end
        else begin rd_wait++; mem_done_i = 1'b0; end
      end else begin
        mem_done_i = 1'b0; rd_wait = 0;
      end
      if (ir_ld_o != 4'b0000) begin
        if (nbytes > 3 || ir_ld_o != (4'b1000 >> nbytes)) strobe_err++;
        case (ir_ld_o)
          4'b1000: ir[31:24] = rdata;
          4'b0100: ir[23:16] = rdata;
          4'b0010: ir[15:8]  = rdata;
          4'b0001: ir[7:0]   = rdata;
          default: strobe_err++;
        endcase
        nbytes++;
      end
      if (fetch_clr_o) begin
        last_ir = ir; last_n = nbytes; last_len = cyc - start_cyc;
        last_exec = exec_set_o; last_addr = addr_set_o;
        ir = '0; nbytes = 0; in_fetch = 0; end_cnt++;
      end
    end
  end

  // ---------------- checking ----------------
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic t_reset_state();
    rst = 1'b1; fetch_req = 1'b0;
    repeat (2) settle();
    chk({mar_ld_o, pc_inc_o, mem_rd_o, ir_ld_o, fetch_clr_o, addr_set_o, exec_set_o} == '0,
        "R11", "outputs in reset",
        {mar_ld_o, pc_inc_o, mem_rd_o, ir_ld_o, fetch_clr_o, addr_set_o, exec_set_o}, 0);
    rst = 1'b0;
    settle();
  endtask

  task automatic t_quiet(input bit run, input bit fet, input string req);
    int m0, r0;
    m0 = mar_cnt; r0 = rd_cnt;
    run_i = run; fetch_req = fet;
    repeat (12) settle();
    chk(mar_cnt == m0 && rd_cnt == r0 && ir_ld_o == 4'b0, req, "strobes while not started",
        mar_cnt - m0 + rd_cnt - r0, 0);
    fetch_req = 1'b0; run_i = 1'b1;
    settle();
  endtask

  task automatic t_fetch(input logic [7:0] op, input int w, input int exp_n,
                         input bit exp_exec, input string req);
    logic [15:0] base;
    logic [31:0] exp_ir;
    int e0, r0, s0, guard;
    bit done;
    base = pc; exp_ir = '0;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b;
      b = (k == 0) ? op : 8'(8'h5A + 8'h11 * k + base[7:0]);
      mem[8'(base[7:0] + k)] = b;
      if (k < exp_n) exp_ir[31 - 8*k -: 8] = b;
    end
    e0 = end_cnt; r0 = rd_cnt; s0 = strobe_err;
    wait_n = w; run_i = 1'b1; fetch_req = 1'b1;
    done = 0; guard = 0;
    while (!done && guard < 2000) begin
      settle(); guard++;
      if (end_cnt != e0) done = 1;
    end
    fetch_req = 1'b0;
    chk(done, req, "watchdog: fetch never ended", guard, 0);
    chk(last_n == exp_n, req, "bytes fetched", last_n, exp_n);
    chk(last_exec == exp_exec && last_addr == !exp_exec, req, "exit flags",
        {last_exec, last_addr}, {exp_exec, !exp_exec});
    chk(last_ir == exp_ir, "R4", "instruction register lanes", last_ir, exp_ir);
    chk(16'(pc - base) == 16'(exp_n), "R2", "program counter advance", pc - base, exp_n);
    chk(last_len == exp_n * (4 + w), "R2", "cycles first address to end", last_len, exp_n * (4 + w));
    chk(rd_cnt - r0 == exp_n * (w + 1), "R3", "read request cycles", rd_cnt - r0, exp_n * (w + 1));
    chk(strobe_err == s0, "R4", "load strobe order", strobe_err - s0, 0);
    settle();
  endtask

  task automatic t_reset_mid_read();
    int guard;
    wait_n = 40; run_i = 1'b1; fetch_req = 1'b1;
    guard = 0;
    while (!mem_rd_o && guard < 100) begin settle(); guard++; end
    repeat (3) settle();
    chk(mem_rd_o, "R3", "read held during waits", mem_rd_o, 1);
    rst = 1'b1; fetch_req = 1'b0;
    settle();
    chk({mar_ld_o, mem_rd_o, ir_ld_o, fetch_clr_o, addr_set_o, exec_set_o} == '0,
        "R11", "outputs after mid-read reset",
        {mar_ld_o, mem_rd_o, ir_ld_o, fetch_clr_o, addr_set_o, exec_set_o}, 0);
    rst = 1'b0;
    repeat (3) settle();
    chk(!mem_rd_o && !mar_ld_o, "R11", "stays idle after reset", mem_rd_o, 0);
  endtask

  bit wd_fired = 0;
  initial begin
    #2_000_000;
    wd_fired = 1;
    $display("FAIL watchdog: global timeout actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    t_reset_state();
    t_quiet(1'b1, 1'b0, "R1");
    t_quiet(1'b0, 1'b1, "R12");
    t_fetch(8'hC5, 0, 1, 1'b1, "R5");
    t_fetch(8'h85, 0, 2, 1'b1, "R6");
    t_fetch(8'h8F, 1, 2, 1'b1, "R6");
    t_fetch(8'h45, 0, 2, 1'b0, "R7");
    t_fetch(8'hA1, 2, 3, 1'b1, "R8");
    t_fetch(8'h12, 0, 4, 1'b0, "R9");
    t_fetch(8'h2E, 3, 4, 1'b0, "R9");
    t_fetch(8'hFF, 5, 1, 1'b1, "R10");
    t_reset_mid_read();
    t_fetch(8'h47, 0, 2, 1'b0, "R11");
    if (!wd_fired) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule